// File: doc/BRIEF.md
# I2C Slave Port Expander Engine

This block is a two-wire serial slave that gives a host one byte of parallel outputs and one byte of sampled inputs. It runs entirely on the system clock. The incoming clock and data lines pass through synchronizers and a spike filter before any edge is looked at. The slave answers on the data line only through an open-drain pull-down enable. The pad driver, clock stretching and multi-master arbitration are handled outside this block.

The address byte arrives most significant bit first. Its upper seven bits are a fixed prefix followed by board strap bits, and the direction flag is the last bit. A write transaction places the first data byte on the output port and ignores anything after it. A read transaction returns a snapshot of the input pins, taking a fresh snapshot for every byte the master acknowledges. Single-cycle strobes mark each port update and each snapshot, so that neighbouring interrupt and port logic can use them.

Top module: `i2c_port_expander`

## Requirements
- R1: The slave acknowledges an address byte only when its seven upper bits equal the fixed prefix 4'b0111 followed by `strap[2]`, `strap[1]`, `strap[0]`, in that order. Bit 0 of the byte selects the direction: 0 means write and 1 means read.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A start seen in any state, including in the middle of a transaction, begins a new address phase. A stop returns the slave to idle with SDA released.
- R3: An address byte that does not match, including the all-zero general call, gets no acknowledge. SDA stays released for the rest of that transaction, and the outputs do not change.
- R4: An acknowledge holds SDA low for the entire high phase of the ninth clock. SDA driven by the slave changes only while SCL is low.
- R5: In a write, the first byte after the address is acknowledged and goes to `port_out`, with bit 7 carried by the first bit on the wire. `wr_strobe` pulses for one cycle when `port_out` updates.
- R6: In a write, bytes after the first are not acknowledged and leave `port_out` and `wr_strobe` untouched.
- R7: `port_out` changes only after a complete byte has been acknowledged. A stop in the middle of a data byte leaves the previous value in place.
- R8: In a read, the input pins are captured on the SCL falling edge that ends the address acknowledge. The captured value is shifted out most significant bit first, and changes on the pins during the byte do not affect it. `rd_strobe` pulses for one cycle at each capture.
- R9: If the master acknowledges (SDA low) after a read byte, a new snapshot is captured and sent. If the master does not acknowledge, the slave releases SDA and stays released until the next start or stop.
- R10: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks (4 by default) is rejected. It causes no bit, start or stop.
- R11: During and after reset, `port_out` is all ones, SDA is released, and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| strap | input | STRAP_W (3) | Board strap bits, the low part of the slave address |
| port_in | input | PORT_W (8) | Input pin values sampled for reads |
| port_out | output | PORT_W (8) | Latched output byte |
| wr_strobe | output | 1 | One-cycle pulse when port_out is updated |
| rd_strobe | output | 1 | One-cycle pulse when port_in is captured |

## Verification
The hardest conditions to reach from the pins are those that depend on what the filter swallows. A clock pulse too short to count, placed inside a data byte, would add a bit if it got through. A rising data spike while the clock is high would look like a stop if it got through. The bench produces both by driving its own bus model below the filter threshold in the middle of a write. It then checks that the latched byte is exactly the value intended. A read snapshot is checked by changing the pins after the first bit has left the slave, and the bench expects the old value for that byte and the new value only after a master acknowledge.

// File: rtl/pexp_pkg.sv
package pexp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,   // waiting for a start
      ST_ADDR,   // shifting in the address byte
      ST_AACK,   // driving the address acknowledge
      ST_WDAT,   // shifting in the write byte
      ST_WACK,   // driving the data acknowledge
      ST_RDAT,   // shifting out the snapshot
      ST_MACK,   // sampling the master acknowledge
      ST_SKIP    // passive until start or stop
   } pexp_state_t;
endpackage

// File: rtl/pexp_deglitch.sv
module pexp_deglitch #(
   parameter int   SYNC_STAGES = 2,
   parameter int   FILT_LEN    = 4,
   parameter logic RST_VAL     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pexp_deglitch: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("pexp_deglitch: FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{RST_VAL}};
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   if (FILT_LEN <= 1) begin : g_nofilt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dout <= RST_VAL;
         else        dout <= synced;
      end
   end else begin : g_filt
      logic [CNT_W-1:0] run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q <= '0;
            dout  <= RST_VAL;
         end else if (synced != dout) begin
            if (run_q == CNT_W'(FILT_LEN-1)) begin
               dout  <= synced;
               run_q <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end else begin
            run_q <= '0;
         end
      end
   end
endmodule

// File: rtl/pexp_linemon.sv
module pexp_linemon (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise  = scl_f & ~scl_q;
   assign scl_fall  = ~scl_f & scl_q;
   assign start_det = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander
   import pexp_pkg::*;
#(
   parameter int                     PORT_W      = 8,
   parameter int                     STRAP_W     = 3,
   parameter logic [6-STRAP_W:0]     ADDR_HI     = 4'b0111,
   parameter int                     SYNC_STAGES = 2,
   parameter int                     FILT_LEN    = 4,
   parameter logic [PORT_W-1:0]      PORT_RESET  = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe,
   input  logic [STRAP_W-1:0] strap,
   input  logic [PORT_W-1:0]  port_in,
   output logic [PORT_W-1:0]  port_out,
   output logic               wr_strobe,
   output logic               rd_strobe
);
   localparam int CNT_W = $clog2(PORT_W + 1);

   if (PORT_W != 8) begin : g_bad_port
      $error("i2c_port_expander: PORT_W must equal the bus byte width 8");
   end
   if (STRAP_W < 1 || STRAP_W > 6) begin : g_bad_strap
      $error("i2c_port_expander: STRAP_W must lie in 1..6");
   end
   if (ADDR_HI == '0) begin : g_bad_hi
      $error("i2c_port_expander: ADDR_HI of zero would answer the general call");
   end

   logic scl_f, sda_f;
   logic scl_rise, scl_fall, start_det, stop_det;

   pexp_deglitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_scl_flt (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));
   pexp_deglitch #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_sda_flt (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

   pexp_linemon u_mon (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   pexp_state_t       state_q;
   logic [PORT_W-1:0] rx_q, tx_q, port_q;
   logic [CNT_W-1:0]  bit_q;
   logic              mack_q, wr_q, rd_q;
   logic              addr_hit, byte_full;

   assign addr_hit  = (rx_q[7:1] == {ADDR_HI, strap});
   assign byte_full = (bit_q == CNT_W'(PORT_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rx_q    <= '0;
         tx_q    <= '0;
         bit_q   <= '0;
         mack_q  <= 1'b1;
         port_q  <= PORT_RESET;
         wr_q    <= 1'b0;
         rd_q    <= 1'b0;
      end else begin
         wr_q <= 1'b0;
         rd_q <= 1'b0;
         if (stop_det) begin
            state_q <= ST_IDLE;
         end else if (start_det) begin
            state_q <= ST_ADDR;
            bit_q   <= '0;
         end else begin
            unique case (state_q)
               ST_ADDR, ST_WDAT: begin
                  if (scl_rise) begin
                     rx_q  <= {rx_q[PORT_W-2:0], sda_f};
                     bit_q <= bit_q + 1'b1;
                  end else if (scl_fall && byte_full) begin
                     if (state_q == ST_WDAT) state_q <= ST_WACK;
                     else if (addr_hit)      state_q <= ST_AACK;
                     else                    state_q <= ST_IDLE;
                  end
               end
               ST_AACK: if (scl_fall) begin
                  bit_q <= '0;
                  if (rx_q[0]) begin
                     tx_q    <= port_in;
                     rd_q    <= 1'b1;
                     state_q <= ST_RDAT;
                  end else begin
                     state_q <= ST_WDAT;
                  end
               end
               ST_WACK: if (scl_fall) begin
                  port_q  <= rx_q;
                  wr_q    <= 1'b1;
                  state_q <= ST_SKIP;
               end
               ST_RDAT: begin
                  if (scl_rise) begin
                     bit_q <= bit_q + 1'b1;
                  end else if (scl_fall) begin
                     if (byte_full) state_q <= ST_MACK;
                     else           tx_q    <= {tx_q[PORT_W-2:0], 1'b0};
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack_q <= sda_f;
                  end else if (scl_fall) begin
                     if (!mack_q) begin
                        tx_q    <= port_in;
                        rd_q    <= 1'b1;
                        bit_q   <= '0;
                        state_q <= ST_RDAT;
                     end else begin
                        state_q <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (state_q)
         ST_AACK, ST_WACK: sda_oe = 1'b1;
         ST_RDAT:          sda_oe = ~tx_q[PORT_W-1];
         default:          sda_oe = 1'b0;
      endcase
   end

   assign port_out  = port_q;
   assign wr_strobe = wr_q;
   assign rd_strobe = rd_q;
endmodule

// File: rtl/pexp_checker.sv
module pexp_checker #(
   parameter int PORT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_f,
   input logic              stop_det,
   input logic              sda_oe,
   input logic [PORT_W-1:0] port_out,
   input logic              wr_strobe
);
   // R4: the slave never moves SDA while the filtered clock stays high
   a_r4_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_f && $past(scl_f)) |-> $stable(sda_oe));

   // R7: any change of the output byte comes with the write strobe
   a_r7_out_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(port_out) |-> wr_strobe);

   // R7: the write strobe follows a cycle in which the slave was acknowledging
   a_r7_strobe_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |-> $past(sda_oe));

   // R2: after a stop the data line is released
   a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);
endmodule

bind i2c_port_expander pexp_checker #(.PORT_W(PORT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .stop_det(stop_det),
   .sda_oe(sda_oe), .port_out(port_out), .wr_strobe(wr_strobe));

// File: tb/i2c_port_expander_bench.sv
module i2c_port_expander_bench;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 16;   // quarter of a bus bit, in clocks
   localparam int FILT       = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic [2:0] strap = 3'd0;
   logic [7:0] port_in = 8'h00;
   logic       sda_oe, wr_strobe, rd_strobe;
   logic [7:0] port_out;
   wire        sda_line = sda_m & ~sda_oe;

   int n_chk = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_port_expander u_i2c_port_expander (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .strap(strap), .port_in(port_in), .port_out(port_out),
      .wr_strobe(wr_strobe), .rd_strobe(rd_strobe));

   always @(negedge clk) begin
      if (wr_strobe) wr_cnt++;
      if (rd_strobe) rd_cnt++;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
   endtask

   // eight bits, then the ninth clock; acked means low at start and end of its high phase
   task automatic put_byte(input logic [7:0] v, output logic acked);
      logic a0, a1;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(1); a0 = sda_line;
      tick(2*Q-2); a1 = sda_line; tick(1); scl_m = 1'b0; tick(Q);
      acked = !a0 && !a1;
   endtask

   task automatic get_byte(input bit swap, input logic [7:0] new_in, output logic [7:0] v);
      logic e0;
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q); scl_m = 1'b1; tick(1); e0 = sda_line; tick(Q-1); v[i] = sda_line;
         tick(Q-1); chk("R4 read bit steady", {31'd0, sda_line}, {31'd0, e0});
         tick(1); scl_m = 1'b0; tick(Q);
         if (swap && i == 7) port_in = new_in;
      end
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic       ack;
      logic [7:0] rd, last_out, rdexp;
      logic [6:0] match, a7;
      int         w0, r0;

      tick(5);
      chk("R11 port_out reset", {24'd0, port_out}, 32'hFF);
      chk("R11 sda released", {31'd0, sda_oe}, 0);
      chk("R11 strobes low", {30'd0, wr_strobe, rd_strobe}, 0);
      rst_n = 1'b1;
      tick(Q);
      chk("R11 port_out after reset", {24'd0, port_out}, 32'hFF);
      last_out = 8'hFF;

      // R1/R3/R5 sweep: every strap value, the matching address and its neighbours
      for (int s = 0; s < 8; s++) begin
         strap = 3'(s);
         match = {4'b0111, 3'(s)};
         tick(Q);
         for (int k = 0; k < 9; k++) begin
            a7 = (k == 0) ? match : (k == 8) ? 7'h00 : (match ^ 7'(1 << (k-1)));
            w0 = wr_cnt;
            bus_start();
            put_byte({a7, 1'b0}, ack);
            chk((k == 8) ? "R3 general call" : "R1 address match", {31'd0, ack},
                {31'd0, (a7 == match)});
            if (a7 == match) begin
               rd = 8'((s * 53 + 17) ^ (s << 5));
               put_byte(rd, ack);
               chk("R5 data ack", {31'd0, ack}, 1);
               last_out = rd;
            end
            bus_stop();
            tick(2);
            chk("R5 port_out value", {24'd0, port_out}, {24'd0, last_out});
            chk("R3 wr strobes", wr_cnt - w0, (a7 == match) ? 1 : 0);
         end
      end

      strap = 3'd3;
      match = 7'b0111011;

      // R6: second data byte ignored
      w0 = wr_cnt;
      bus_start();
      put_byte({match, 1'b0}, ack);
      put_byte(8'h5A, ack);
      chk("R6 first byte acked", {31'd0, ack}, 1);
      put_byte(8'hC3, ack);
      chk("R6 second byte not acked", {31'd0, ack}, 0);
      bus_stop(); tick(2);
      chk("R6 port_out keeps first", {24'd0, port_out}, 32'h5A);
      chk("R6 one strobe", wr_cnt - w0, 1);

      // R7: stop part-way through a data byte
      bus_start();
      put_byte({match, 1'b0}, ack);
      put_bit(1'b0); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
      bus_stop(); tick(2);
      chk("R7 partial byte discarded", {24'd0, port_out}, 32'h5A);

      // R10: short clock pulses while low and short data pulses while high
      w0 = wr_cnt;
      bus_start();
      put_byte({match, 1'b0}, ack);
      rd = 8'h96;
      for (int i = 7; i >= 0; i--) begin
         sda_m = rd[i]; tick(4);
         scl_m = 1'b1; tick(FILT-1); scl_m = 1'b0; tick(Q-4-(FILT-1));
         scl_m = 1'b1; tick(Q);
         if (!rd[i]) begin
            sda_m = 1'b1; tick(FILT-1); sda_m = 1'b0; tick(Q-(FILT-1));
         end else begin
            tick(Q);
         end
         scl_m = 1'b0; tick(Q);
      end
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      chk("R10 ack despite spikes", {31'd0, sda_line}, 0);
      tick(Q); scl_m = 1'b0; tick(Q);
      bus_stop(); tick(2);
      chk("R10 port_out after spikes", {24'd0, port_out}, 32'h96);
      chk("R10 one strobe", wr_cnt - w0, 1);

      // R8/R9: snapshot held during a byte, fresh snapshot after master ack, release after nack
      port_in = 8'hA5;
      r0 = rd_cnt;
      bus_start();
      put_byte({match, 1'b1}, ack);
      chk("R1 read address acked", {31'd0, ack}, 1);
      get_byte(1'b1, 8'h3C, rd);
      chk("R8 snapshot held", {24'd0, rd}, 32'hA5);
      put_bit(1'b0);
      get_byte(1'b0, 8'h00, rd);
      chk("R9 fresh snapshot after ack", {24'd0, rd}, 32'h3C);
      chk("R8 two captures", rd_cnt - r0, 2);
      put_bit(1'b1);
      port_in = 8'h00;
      get_byte(1'b0, 8'h00, rd);
      chk("R9 released after nack", {24'd0, rd}, 32'hFF);
      chk("R9 no capture after nack", rd_cnt - r0, 2);
      bus_stop();

      // R2: repeated start turns a write into a read
      port_in = 8'h4E;
      bus_start();
      put_byte({match, 1'b0}, ack);
      put_byte(8'h21, ack);
      bus_start();
      put_byte({match, 1'b1}, ack);
      chk("R2 repeated start address acked", {31'd0, ack}, 1);
      get_byte(1'b0, 8'h00, rd);
      chk("R2 read after repeated start", {24'd0, rd}, 32'h4E);
      put_bit(1'b1);
      bus_stop(); tick(2);
      chk("R2 write kept", {24'd0, port_out}, 32'h21);
      chk("R2 released after stop", {31'd0, sda_oe}, 0);

      // R3: a read to another address drives nothing
      bus_start();
      put_byte({match ^ 7'h01, 1'b1}, ack);
      chk("R3 wrong read address", {31'd0, ack}, 0);
      get_byte(1'b0, 8'h00, rd);
      chk("R3 line idle", {24'd0, rd}, 32'hFF);
      bus_stop();

      // R8 sweep: walking one and walking zero over two acked reads
      for (int k = 0; k < 8; k++) begin
         port_in = 8'(1 << k);
         bus_start();
         put_byte({match, 1'b1}, ack);
         get_byte(1'b1, ~8'(1 << k), rd);
         chk("R8 walking one", {24'd0, rd}, {24'd0, 8'(1 << k)});
         put_bit(1'b0);
         get_byte(1'b0, 8'h00, rd);
         rdexp = ~8'(1 << k);
         chk("R9 walking zero", {24'd0, rd}, {24'd0, rdexp});
         put_bit(1'b1);
         bus_stop();
      end

      done = 1'b1;
      tick(4);
      finish_run();
   end
endmodule